// File: doc/BRIEF.md
# Page-Splitting Block Mover

This block is a single-channel direct memory access engine. Software sets up four things through a small register port: a fixed I/O device address, a memory start address, a byte count and a direction. It then writes the start bit. From then on the engine moves 32-bit words between a device port and a memory port without further processor help. When the last word has moved, it raises an interrupt.

The memory port is shared with other bus masters, so the engine asks for it with a request/grant pair. Memory addresses are physical, and physical pages need not be contiguous, so no burst may run past the end of a page. The engine cuts every transfer into segments. Each segment is the smaller of the bytes still to move and the bytes left before the next page boundary. It gives up the bus after each segment and arbitrates again before the next one. The page size is 2^PAGE_BITS bytes (4 KB by default).

Register map (`cfg_addr`):
- 0: device address.
- 1: memory start address.
- 2: byte count.
- 3: control. Bit 0 is start. Bit 1 is the direction: 0 moves device to memory, 1 moves memory to device.
- 4: status. Bit 0 is busy, bit 1 is done, bit 2 is error.

Top module: `pgdma_top`

## Requirements
- R1: After reset the status register reads 0, and `irq`, `bus_req` and all four access strobes are low.
- R2: The device address, memory address and byte count registers read back the value last written, truncated to their widths. Read data appears on `cfg_rdata` one cycle after `cfg_rd`.
- R3: With direction 0, each word is read from the device at the programmed device address and written to consecutive word addresses starting at the memory start address, in order.
- R4: With direction 1, words are read from consecutive memory addresses starting at the start address and written in order to the device at the programmed device address.
- R5: No device or memory strobe is issued unless `bus_req` and `bus_gnt` are both high. After raising `bus_req`, the engine waits for `bus_gnt`.
- R6: All memory accesses made while `bus_req` stays high fall in one page of 2^PAGE_BITS bytes. Each segment length is min(remaining bytes, distance to the next page boundary).
- R7: `bus_req` falls for at least one cycle between segments, so the number of rising edges of `bus_req` in a transfer equals its segment count.
- R8: Status busy (bit 0) is 1 while a transfer runs. At the end, busy is 0, done (bit 1) is 1, and `irq` is high while done is set. `bus_req` is low whenever `irq` is high.
- R9: Writing the status register with bit 1 set clears done and error, and `irq` falls.
- R10: A start with a byte count of 0 sets done and `irq` at once, without raising `bus_req`.
- R11: A start with a byte count that is not a multiple of 4, or a memory address that is not 4-aligned, sets error (bit 2) and done without any bus request or access.
- R12: A start written while busy is ignored. The running transfer completes as programmed.
- R13: At most one of the four access strobes is high in any cycle, and memory addresses are always word-aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | 3 | Register index |
| cfg_wdata | input | DW | Register write data |
| cfg_rdata | output | DW | Register read data, valid one cycle after `cfg_rd` |
| irq | output | 1 | Completion interrupt (level, equal to done) |
| bus_req | output | 1 | Shared bus request |
| bus_gnt | input | 1 | Shared bus grant |
| dev_addr | output | AW | Device address |
| dev_rd | output | 1 | Device read strobe, data expected next cycle |
| dev_rdata | input | DW | Device read data |
| dev_wr | output | 1 | Device write strobe |
| dev_wdata | output | DW | Device write data |
| mem_addr | output | AW | Memory byte address |
| mem_rd | output | 1 | Memory read strobe, data expected next cycle |
| mem_rdata | input | DW | Memory read data |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Memory write data |

## Verification
The bench builds the block with PAGE_BITS=6 and CW=12, which gives 64-byte pages. With these values, transfers of a few dozen words cross one, two or three page boundaries. That brings into reach first and last segments of a single word, an exact full-page segment, and several chained segments, without long runs. The grant comes two cycles after each request, so the bench also sees the engine wait for the grant and re-arbitrate between segments.

// File: rtl/pgdma_pkg.sv
package pgdma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARB,
    ST_RD,
    ST_WR,
    ST_GAP
  } eng_state_t;

  localparam logic [2:0] REG_DEV = 3'd0;
  localparam logic [2:0] REG_MEM = 3'd1;
  localparam logic [2:0] REG_LEN = 3'd2;
  localparam logic [2:0] REG_CTL = 3'd3;
  localparam logic [2:0] REG_STS = 3'd4;

  localparam int CTL_GO  = 0;
  localparam int CTL_DIR = 1;
  localparam int STS_DONE = 1;
endpackage

// File: rtl/pgdma_regs.sv
module pgdma_regs #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  logic          cfg_rd,
  input  logic [2:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          busy,
  input  logic          fin_pulse,
  input  logic          fin_err,
  output logic [AW-1:0] dev_base,
  output logic [AW-1:0] mem_base,
  output logic [CW-1:0] len,
  output logic          dir,
  output logic          go,
  output logic          irq
);
  import pgdma_pkg::*;

  logic done_q, err_q;
  logic go_req;

  assign go_req = cfg_wr && (cfg_addr == REG_CTL) && cfg_wdata[CTL_GO] && !busy && !go;

  always_ff @(posedge clk) begin
    if (rst) begin
      dev_base <= '0;
      mem_base <= '0;
      len      <= '0;
      dir      <= 1'b0;
      go       <= 1'b0;
    end else begin
      go <= go_req;
      if (cfg_wr) begin
        case (cfg_addr)
          REG_DEV: dev_base <= cfg_wdata[AW-1:0];
          REG_MEM: mem_base <= cfg_wdata[AW-1:0];
          REG_LEN: len      <= cfg_wdata[CW-1:0];
          REG_CTL: if (go_req) dir <= cfg_wdata[CTL_DIR];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (fin_pulse) begin
      done_q <= 1'b1;
      err_q  <= fin_err;
    end else if (go || (cfg_wr && cfg_addr == REG_STS && cfg_wdata[STS_DONE])) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end
  end

  assign irq = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
    end else if (cfg_rd) begin
      case (cfg_addr)
        REG_DEV: cfg_rdata <= DW'(dev_base);
        REG_MEM: cfg_rdata <= DW'(mem_base);
        REG_LEN: cfg_rdata <= DW'(len);
        REG_CTL: cfg_rdata <= DW'({dir, 1'b0});
        REG_STS: cfg_rdata <= DW'({err_q, done_q, busy});
        default: cfg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/pgdma_seg.sv
module pgdma_seg #(
  parameter int CW        = 20,
  parameter int PAGE_BITS = 12
) (
  input  logic [PAGE_BITS-1:0] page_off,
  input  logic [CW-1:0]        remain,
  output logic [CW-1:0]        seg_len
);
  localparam logic [CW-1:0] PAGE_SZ = CW'(1) << PAGE_BITS;

  logic [CW-1:0] to_edge;

  always_comb begin
    to_edge = PAGE_SZ - CW'(page_off);
    seg_len = (remain < to_edge) ? remain : to_edge;
  end
endmodule

// File: rtl/pgdma_engine.sv
module pgdma_engine #(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int CW        = 20,
  parameter int PAGE_BITS = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          dir_in,
  input  logic [AW-1:0] dev_base,
  input  logic [AW-1:0] mem_base,
  input  logic [CW-1:0] len,
  input  logic          bus_gnt,
  input  logic [DW-1:0] dev_rdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          fin_pulse,
  output logic          fin_err,
  output logic          bus_req,
  output logic [AW-1:0] dev_addr,
  output logic          dev_rd,
  output logic          dev_wr,
  output logic [DW-1:0] dev_wdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata
);
  import pgdma_pkg::*;

  localparam logic [CW-1:0] WORD_B = CW'(4);
  localparam logic [AW-1:0] WORD_A = AW'(4);

  eng_state_t    state;
  logic          dir_q;
  logic [AW-1:0] dev_q, cur_mem;
  logic [CW-1:0] rem, seg_rem, seg_len;

  pgdma_seg #(.CW(CW), .PAGE_BITS(PAGE_BITS)) i_seg (
    .page_off (cur_mem[PAGE_BITS-1:0]),
    .remain   (rem),
    .seg_len  (seg_len)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      dir_q     <= 1'b0;
      dev_q     <= '0;
      cur_mem   <= '0;
      rem       <= '0;
      seg_rem   <= '0;
      fin_pulse <= 1'b0;
      fin_err   <= 1'b0;
    end else begin
      fin_pulse <= 1'b0;
      case (state)
        ST_IDLE: if (go) begin
          dir_q   <= dir_in;
          dev_q   <= dev_base;
          cur_mem <= mem_base;
          rem     <= len;
          if (len[1:0] != 2'b00 || mem_base[1:0] != 2'b00) begin
            fin_pulse <= 1'b1;
            fin_err   <= 1'b1;
          end else if (len == '0) begin
            fin_pulse <= 1'b1;
            fin_err   <= 1'b0;
          end else begin
            state <= ST_ARB;
          end
        end
        ST_ARB: if (bus_gnt) begin
          seg_rem <= seg_len;
          state   <= ST_RD;
        end
        ST_RD: state <= ST_WR;
        ST_WR: begin
          cur_mem <= cur_mem + WORD_A;
          rem     <= rem - WORD_B;
          seg_rem <= seg_rem - WORD_B;
          if (rem == WORD_B) begin
            state     <= ST_IDLE;
            fin_pulse <= 1'b1;
            fin_err   <= 1'b0;
          end else if (seg_rem == WORD_B) begin
            state <= ST_GAP;
          end else begin
            state <= ST_RD;
          end
        end
        ST_GAP: state <= ST_ARB;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign bus_req   = (state == ST_ARB) || (state == ST_RD) || (state == ST_WR);
  assign dev_addr  = dev_q;
  assign mem_addr  = cur_mem;
  assign dev_rd    = (state == ST_RD) && !dir_q;
  assign mem_rd    = (state == ST_RD) && dir_q;
  assign mem_wr    = (state == ST_WR) && !dir_q;
  assign dev_wr    = (state == ST_WR) && dir_q;
  assign mem_wdata = dev_rdata;
  assign dev_wdata = mem_rdata;
endmodule

// File: rtl/pgdma_top.sv
module pgdma_top #(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int CW        = 20,
  parameter int PAGE_BITS = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  logic          cfg_rd,
  input  logic [2:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  output logic          irq,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [AW-1:0] dev_addr,
  output logic          dev_rd,
  input  logic [DW-1:0] dev_rdata,
  output logic          dev_wr,
  output logic [DW-1:0] dev_wdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata
);
  logic          busy, fin_pulse, fin_err, go, dir;
  logic [AW-1:0] dev_base, mem_base;
  logic [CW-1:0] len;

  pgdma_regs #(.AW(AW), .DW(DW), .CW(CW)) i_regs (
    .clk, .rst, .cfg_wr, .cfg_rd, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .busy, .fin_pulse, .fin_err,
    .dev_base, .mem_base, .len, .dir, .go, .irq
  );

  pgdma_engine #(.AW(AW), .DW(DW), .CW(CW), .PAGE_BITS(PAGE_BITS)) i_eng (
    .clk, .rst, .go, .dir_in(dir), .dev_base, .mem_base, .len,
    .bus_gnt, .dev_rdata, .mem_rdata,
    .busy, .fin_pulse, .fin_err, .bus_req,
    .dev_addr, .dev_rd, .dev_wr, .dev_wdata,
    .mem_addr, .mem_rd, .mem_wr, .mem_wdata
  );
endmodule

// File: rtl/pgdma_chk.sv
module pgdma_chk #(
  parameter int AW        = 32,
  parameter int PAGE_BITS = 12
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    irq,
  input logic                    bus_req,
  input logic                    bus_gnt,
  input logic                    dev_rd,
  input logic                    dev_wr,
  input logic                    mem_rd,
  input logic                    mem_wr,
  input logic [AW-PAGE_BITS-1:0] mem_page,
  input logic [1:0]              mem_low
);
  logic                    seg_open;
  logic [AW-PAGE_BITS-1:0] seg_page;

  always_ff @(posedge clk) begin
    if (rst || !bus_req) begin
      seg_open <= 1'b0;
      seg_page <= '0;
    end else if (mem_rd || mem_wr) begin
      seg_open <= 1'b1;
      seg_page <= mem_page;
    end
  end

  AST_ACCESS_GRANTED: assert property (@(posedge clk) disable iff (rst) (dev_rd || dev_wr || mem_rd || mem_wr) |-> (bus_req && bus_gnt)); // R5
  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (rst) ((mem_rd || mem_wr) && seg_open) |-> (mem_page == seg_page)); // R6
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst) $onehot0({dev_rd, dev_wr, mem_rd, mem_wr})); // R13
  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (rst) (mem_rd || mem_wr) |-> (mem_low == 2'b00)); // R13
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst) irq |-> !bus_req); // R8
endmodule

bind pgdma_top pgdma_chk #(.AW(AW), .PAGE_BITS(PAGE_BITS)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .irq      (irq),
  .bus_req  (bus_req),
  .bus_gnt  (bus_gnt),
  .dev_rd   (dev_rd),
  .dev_wr   (dev_wr),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr),
  .mem_page (mem_addr[AW-1:PAGE_BITS]),
  .mem_low  (mem_addr[1:0])
);

// File: tb/test_pgdma_top.sv
module test_pgdma_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int CW = 12;
  localparam int PB = 6;
  localparam int GNT_DLY = 2;
  localparam int NV = 6;
  localparam logic [31:0] DEV_A = 32'h0000_0A40;

  // stimulus table: direction, memory start, byte count, expected segments
  localparam int V_DIR [NV] = '{0, 0, 1, 1, 0, 0};
  localparam int V_ADR [NV] = '{'h000, 'h038, 'h080, 'h0FC, 'h104, 'h1C0};
  localparam int V_LEN [NV] = '{16, 16, 64, 72, 200, 4};
  localparam int V_SEG [NV] = '{1, 2, 1, 3, 4, 1};

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [DW-1:0] cfg_wdata = '0, cfg_rdata;
  logic irq, bus_req, bus_gnt;
  logic [AW-1:0] dev_addr, mem_addr;
  logic dev_rd, dev_wr, mem_rd, mem_wr;
  logic [DW-1:0] dev_rdata, dev_wdata, mem_rdata, mem_wdata;

  int n_chk = 0, n_err = 0;
  logic clr = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgdma_top #(.AW(AW), .DW(DW), .CW(CW), .PAGE_BITS(PB)) i_pgdma_top (
    .clk, .rst, .cfg_wr, .cfg_rd, .cfg_addr, .cfg_wdata, .cfg_rdata, .irq,
    .bus_req, .bus_gnt, .dev_addr, .dev_rd, .dev_rdata, .dev_wr, .dev_wdata,
    .mem_addr, .mem_rd, .mem_rdata, .mem_wr, .mem_wdata
  );

  // models: arbiter, device, memory, monitor
  logic [DW-1:0] mem [256];
  logic          written [256];
  logic [DW-1:0] dev_log [128];
  int gcnt, dev_rcnt, dev_wcnt, mwr_cnt, seg_cnt, viol_bus, viol_page, viol_dev;
  logic req_q, pg_open;
  logic [AW-PB-1:0] pg;

  always @(posedge clk) begin
    if (rst || !bus_req) begin
      gcnt <= 0; bus_gnt <= 1'b0;
    end else if (gcnt == GNT_DLY) bus_gnt <= 1'b1;
    else gcnt <= gcnt + 1;
  end

  always @(posedge clk) begin
    if (rst || clr) begin
      dev_rcnt <= 0; dev_wcnt <= 0; mwr_cnt <= 0; seg_cnt <= 0;
      viol_bus <= 0; viol_page <= 0; viol_dev <= 0;
      req_q <= 1'b0; pg_open <= 1'b0; pg <= '0;
      dev_rdata <= '0; mem_rdata <= '0;
      for (int i = 0; i < 256; i++) written[i] <= 1'b0;
    end else begin
      req_q <= bus_req;
      if (bus_req && !req_q) seg_cnt <= seg_cnt + 1;
      if ((dev_rd || dev_wr || mem_rd || mem_wr) && !(bus_req && bus_gnt)) viol_bus <= viol_bus + 1;
      if ((dev_rd || dev_wr) && dev_addr != DEV_A) viol_dev <= viol_dev + 1;
      if (!bus_req) pg_open <= 1'b0;
      else if (mem_rd || mem_wr) begin
        if (pg_open && pg != mem_addr[AW-1:PB]) viol_page <= viol_page + 1;
        pg_open <= 1'b1;
        pg <= mem_addr[AW-1:PB];
      end
      if (dev_rd) begin
        dev_rdata <= 32'hD000_0000 + dev_rcnt;
        dev_rcnt <= dev_rcnt + 1;
      end
      if (dev_wr) begin
        dev_log[dev_wcnt[6:0]] <= dev_wdata;
        dev_wcnt <= dev_wcnt + 1;
      end
      if (mem_rd)
        mem_rdata <= written[mem_addr[9:2]] ? mem[mem_addr[9:2]] : (32'h5000_0000 | mem_addr);
      if (mem_wr) begin
        mem[mem_addr[9:2]] <= mem_wdata;
        written[mem_addr[9:2]] <= 1'b1;
        mwr_cnt <= mwr_cnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); cfg_rd = 1'b1; cfg_addr = a;
    @(negedge clk); cfg_rd = 1'b0; d = cfg_rdata;
  endtask

  task automatic clear_mon();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq && n < 3000) begin @(negedge clk); n++; end
    chk(irq, req, {31'd0, irq}, 32'd1);
  endtask

  task automatic ack_done();
    logic [31:0] s;
    wr_reg(3'd4, 32'h2);
    chk(!irq, "R9 irq cleared", {31'd0, irq}, 32'd0);
    rd_reg(3'd4, s);
    chk(s == 32'd0, "R9 status cleared", s, 32'd0);
  endtask

  task automatic run_xfer(input int dir, input int adr, input int len, input int segs);
    logic [31:0] s;
    clear_mon();
    wr_reg(3'd0, DEV_A);
    wr_reg(3'd1, 32'(adr));
    wr_reg(3'd2, 32'(len));
    wr_reg(3'd3, {30'd0, dir[0], 1'b1});
    wait_irq("R8 irq at end");
    rd_reg(3'd4, s);
    chk(s == 32'h2, "R8 status done", s, 32'h2);
    chk(seg_cnt == segs, "R7 segment count", 32'(seg_cnt), 32'(segs));
    chk(viol_bus == 0, "R5 access without grant", 32'(viol_bus), 0);
    chk(viol_page == 0, "R6 page crossing", 32'(viol_page), 0);
    chk(viol_dev == 0, "R3 device address", 32'(viol_dev), 0);
    if (dir == 0) begin
      chk(mwr_cnt == len/4, "R3 memory write count", 32'(mwr_cnt), 32'(len/4));
      for (int k = 0; k < len/4; k++)
        chk(mem[((adr>>2)+k) & 255] == 32'hD000_0000 + 32'(k), "R3 memory word",
            mem[((adr>>2)+k) & 255], 32'hD000_0000 + 32'(k));
    end else begin
      chk(dev_wcnt == len/4, "R4 device write count", 32'(dev_wcnt), 32'(len/4));
      for (int k = 0; k < len/4; k++)
        chk(dev_log[k] == (32'h5000_0000 | 32'(adr + 4*k)), "R4 device word",
            dev_log[k], 32'h5000_0000 | 32'(adr + 4*k));
    end
    ack_done();
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] s;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!irq && !bus_req, "R1 irq/bus_req after reset", {30'd0, irq, bus_req}, 0);
    chk(!(dev_rd || dev_wr || mem_rd || mem_wr), "R1 strobes after reset",
        {28'd0, dev_rd, dev_wr, mem_rd, mem_wr}, 0);
    rd_reg(3'd4, s);
    chk(s == 0, "R1 status after reset", s, 0);

    // R2 register readback
    wr_reg(3'd0, 32'h1234_5678); rd_reg(3'd0, s);
    chk(s == 32'h1234_5678, "R2 device address readback", s, 32'h1234_5678);
    wr_reg(3'd1, 32'h0000_0ABC); rd_reg(3'd1, s);
    chk(s == 32'h0000_0ABC, "R2 memory address readback", s, 32'h0000_0ABC);
    wr_reg(3'd2, 32'hFFFF_FABC); rd_reg(3'd2, s);
    chk(s == 32'h0000_0ABC, "R2 count readback truncated", s, 32'h0000_0ABC);

    // table walk: R3 R4 R6 R7 R8 R9
    for (int v = 0; v < NV; v++) run_xfer(V_DIR[v], V_ADR[v], V_LEN[v], V_SEG[v]);

    // R10 zero count
    clear_mon();
    wr_reg(3'd1, 32'h10); wr_reg(3'd2, 0); wr_reg(3'd3, 32'h1);
    wait_irq("R10 irq on zero count");
    rd_reg(3'd4, s);
    chk(s == 32'h2, "R10 status done", s, 32'h2);
    chk(seg_cnt == 0, "R10 no bus request", 32'(seg_cnt), 0);
    ack_done();

    // R11 count not a word multiple
    clear_mon();
    wr_reg(3'd1, 32'h20); wr_reg(3'd2, 6); wr_reg(3'd3, 32'h1);
    wait_irq("R11 irq on bad count");
    rd_reg(3'd4, s);
    chk(s == 32'h6, "R11 error on bad count", s, 32'h6);
    chk(seg_cnt == 0 && mwr_cnt == 0, "R11 no request/access", 32'(seg_cnt + mwr_cnt), 0);
    ack_done();
    // R11 misaligned memory address
    clear_mon();
    wr_reg(3'd1, 32'h102); wr_reg(3'd2, 8); wr_reg(3'd3, 32'h3);
    wait_irq("R11 irq on bad address");
    rd_reg(3'd4, s);
    chk(s == 32'h6, "R11 error on bad address", s, 32'h6);
    chk(seg_cnt == 0 && dev_wcnt == 0, "R11 no request/access", 32'(seg_cnt + dev_wcnt), 0);
    ack_done();

    // R12 start while busy is ignored; R8 busy while running
    clear_mon();
    wr_reg(3'd0, DEV_A); wr_reg(3'd1, 32'h0); wr_reg(3'd2, 128); wr_reg(3'd3, 32'h1);
    repeat (4) @(negedge clk);
    rd_reg(3'd4, s);
    chk(s == 32'h1, "R8 busy while running", s, 32'h1);
    wr_reg(3'd3, 32'h3);
    wait_irq("R12 irq after ignored start");
    chk(seg_cnt == 2, "R12 segments of first start", 32'(seg_cnt), 2);
    chk(mwr_cnt == 32 && dev_wcnt == 0, "R12 direction kept",
        32'(mwr_cnt), 32);
    repeat (4) @(negedge clk);
    chk(!bus_req && seg_cnt == 2, "R12 no second transfer", 32'(seg_cnt), 2);
    ack_done();

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule